// File: doc/BRIEF.md
# Bus Access Error Collector

This block gathers illegal-access reports from a set of peripheral error lines. Each line feeds one sticky status bit. The bit is set on a rising edge of the line, but only while global capture is turned on. Status bits, their interrupt enables and their clear strobes are organised in 32-bit banks. Line ID n sits in bank n/32 at bit position n%32. One level-sensitive interrupt is high while any status bit that is also enabled remains set.

Software talks to the block through a plain 32-bit register port that uses byte addresses. After reset, firmware turns capture on and writes the enable banks. When the interrupt arrives, it reads the status banks to find the offending line IDs and writes ones to the clear banks to acknowledge them. A configuration register reports the number of implemented lines, and a version register reports the revision, so that software can size its loops.

Top module: `bus_err_collector`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, capture is off (control bit 0 reads 0), `irq` is low and `rsp_rdata` is 0.
- R2: A rising edge on line n while control bit 0 is 1 sets bit n%32 of the status register at byte offset 0x040 + 4*(n/32), in the clock edge that samples the line high. A line that stays high does not raise a second event. An edge that occurs while capture is off is lost.
- R3: A status bit stays set, whatever the line does afterwards, until software clears it.
- R4: Writing the clear register at 0x080 + 4*b clears each status bit of bank b whose write-data bit is 1. Bits written as 0 are unaffected. A read of a clear register returns 0.
- R5: When a new event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: The enable register at 0x000 + 4*b is readable and writable. `irq` is 1 exactly when the bitwise AND of some status bank with its enable bank is nonzero.
- R7: The status and enable bits of line IDs at or above NUM_LINES read as 0. Registers of banks that do not exist read as 0.
- R8: The control register sits at 0x100. Bit 0 is the capture enable and can be read back. All its other bits read as 0.
- R9: Register 0x3F0 reads NUM_LINES in bits [7:0] and AUX_CFG in bits [18:16]. Register 0x3F4 reads the major revision in bits [7:4] and the minor revision in bits [3:0]. Writes to status, configuration and version registers have no effect.
- R10: A read request is answered on `rsp_rdata` after the next clock edge. The value then holds until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_lines | input | NUM_LINES | Error event lines, one per line ID |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address (bits [1:0] ignored) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: some enabled status bit is set |

## Verification
The assertions check four things on every cycle. A status bit never drops without a clear write. A captured event survives a clear of the same bit in the same cycle. The interrupt output agrees with the status and enable banks. A clear register always reads back zero. Only the bench's scenarios can show the rest: the mapping of each line ID to its bank and bit, the loss of edges while capture is off, the absence of a second event from a held line, the zero readback for unimplemented IDs, and the contents of the discovery registers.

// File: rtl/bec_pkg.sv
package bec_pkg;
    localparam int unsigned BANK_W = 32;
    localparam int unsigned ADDR_W = 10;

    // Word-address regions (byte address >> 6) of the banked registers
    localparam logic [3:0] REGION_EN  = 4'h0;
    localparam logic [3:0] REGION_ST  = 4'h1;
    localparam logic [3:0] REGION_CLR = 4'h2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 10'h100;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 10'h3F0;
    localparam logic [ADDR_W-1:0] OFS_VER  = 10'h3F4;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_EN, SEL_ST, SEL_CLR, SEL_CTRL, SEL_CFG, SEL_VER
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] status;
        logic [BANK_W-1:0] enable;
    } bank_state_t;

    typedef struct packed {
        logic              cap_en;
        logic [BANK_W-1:0] rdata;
    } port_state_t;
endpackage

// File: rtl/bec_edge.sv
module bec_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lines_i;
        rise_o = lines_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/bec_bank.sv
module bec_bank
    import bec_pkg::*;
#(
    parameter int unsigned IMPL_LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] rise_i,
    input  logic              cap_en_i,
    input  logic              en_we_i,
    input  logic              clr_we_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] status_o,
    output logic [BANK_W-1:0] enable_o,
    output logic              irq_o
);
    localparam logic [BANK_W-1:0] IMPL_MASK = 32'hFFFF_FFFF >> (BANK_W - IMPL_LINES);

    bank_state_t       st_d, st_q;
    logic [BANK_W-1:0] set_vec, clr_vec;

    always_comb begin
        st_d    = st_q;
        set_vec = cap_en_i ? (rise_i & IMPL_MASK) : '0;
        clr_vec = clr_we_i ? wdata_i : '0;
        if (en_we_i) st_d.enable = wdata_i & IMPL_MASK;
        // a fresh event overrides a clear of the same bit
        st_d.status = (st_q.status & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign enable_o = st_q.enable;
    assign irq_o    = |(st_q.status & st_q.enable);

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_i && ((rise_i & IMPL_MASK) != '0))
        |=> ((status_o & $past(rise_i & IMPL_MASK)) == $past(rise_i & IMPL_MASK)));

    a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !cap_en_i) |=> ((status_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/bec_regport.sv
module bec_regport
    import bec_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 1,
    parameter int unsigned NUM_LINES = 32,
    parameter logic [2:0]  AUX_CFG   = 3'd0,
    parameter logic [3:0]  REV_MAJOR = 4'd1,
    parameter logic [3:0]  REV_MINOR = 4'd0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [BANK_W-1:0]             req_wdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   status_flat,
    input  logic [NUM_BANKS*BANK_W-1:0]   enable_flat,
    output logic [NUM_BANKS-1:0]          en_we,
    output logic [NUM_BANKS-1:0]          clr_we,
    output logic                          cap_en,
    output logic [BANK_W-1:0]             rdata
);
    localparam logic [BANK_W-1:0] CFG_WORD = {13'd0, AUX_CFG, 8'd0, NUM_LINES[7:0]};
    localparam logic [BANK_W-1:0] VER_WORD = {24'd0, REV_MAJOR, REV_MINOR};

    port_state_t       ps_d, ps_q;
    reg_sel_e          sel;
    logic [3:0]        bidx;
    logic              bank_hit;
    logic [BANK_W-1:0] st_word, en_word;
    logic              wr, rd;

    always_comb begin
        bidx = req_addr[5:2];
        wr   = req_valid && req_write;
        rd   = req_valid && !req_write;
        unique case (req_addr[9:6])
            REGION_EN:  sel = SEL_EN;
            REGION_ST:  sel = SEL_ST;
            REGION_CLR: sel = SEL_CLR;
            default:    sel = SEL_NONE;
        endcase
        if      (req_addr[9:2] == OFS_CTRL[9:2]) sel = SEL_CTRL;
        else if (req_addr[9:2] == OFS_CFG[9:2])  sel = SEL_CFG;
        else if (req_addr[9:2] == OFS_VER[9:2])  sel = SEL_VER;

        bank_hit = 1'b0;
        st_word  = '0;
        en_word  = '0;
        en_we    = '0;
        clr_we   = '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (bidx == 4'(b)) begin
                bank_hit  = 1'b1;
                st_word   = status_flat[b*BANK_W +: BANK_W];
                en_word   = enable_flat[b*BANK_W +: BANK_W];
                en_we[b]  = wr && (sel == SEL_EN);
                clr_we[b] = wr && (sel == SEL_CLR);
            end
        end

        ps_d = ps_q;
        if (wr && sel == SEL_CTRL) ps_d.cap_en = req_wdata[0];
        if (rd) begin
            unique case (sel)
                SEL_EN:   ps_d.rdata = bank_hit ? en_word : '0;
                SEL_ST:   ps_d.rdata = bank_hit ? st_word : '0;
                SEL_CTRL: ps_d.rdata = {31'd0, ps_q.cap_en};
                SEL_CFG:  ps_d.rdata = CFG_WORD;
                SEL_VER:  ps_d.rdata = VER_WORD;
                default:  ps_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign cap_en = ps_q.cap_en;
    assign rdata  = ps_q.rdata;

    a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[9:6] == REGION_CLR) |=> (rdata == '0));
endmodule

// File: rtl/bus_err_collector.sv
module bus_err_collector
    import bec_pkg::*;
#(
    parameter int unsigned NUM_LINES = 160,
    parameter logic [2:0]  AUX_CFG   = 3'd0,
    parameter logic [3:0]  REV_MAJOR = 4'd1,
    parameter logic [3:0]  REV_MINOR = 4'd0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] err_lines,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [9:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rsp_rdata,
    output logic                 irq
);
    localparam int unsigned NUM_BANKS = (NUM_LINES + BANK_W - 1) / BANK_W;
    localparam int unsigned PAD_W     = NUM_BANKS * BANK_W;

    logic [PAD_W-1:0]     lines_pad, rise_flat, status_flat, enable_flat;
    logic [NUM_BANKS-1:0] en_we, clr_we, bank_irq;
    logic                 cap_en;

    assign lines_pad = PAD_W'(err_lines);

    bec_edge #(.WIDTH(PAD_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines_i(lines_pad), .rise_o(rise_flat)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int unsigned LEFT = NUM_LINES - b * BANK_W;
        localparam int unsigned IMPL = (LEFT > BANK_W) ? BANK_W : LEFT;
        bec_bank #(.IMPL_LINES(IMPL)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_i   (rise_flat[b*BANK_W +: BANK_W]),
            .cap_en_i (cap_en),
            .en_we_i  (en_we[b]),
            .clr_we_i (clr_we[b]),
            .wdata_i  (req_wdata),
            .status_o (status_flat[b*BANK_W +: BANK_W]),
            .enable_o (enable_flat[b*BANK_W +: BANK_W]),
            .irq_o    (bank_irq[b])
        );
    end

    bec_regport #(
        .NUM_BANKS(NUM_BANKS), .NUM_LINES(NUM_LINES), .AUX_CFG(AUX_CFG),
        .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
    ) u_regport (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .status_flat(status_flat),
        .enable_flat(enable_flat),
        .en_we      (en_we),
        .clr_we     (clr_we),
        .cap_en     (cap_en),
        .rdata      (rsp_rdata)
    );

    assign irq = |bank_irq;

    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((status_flat & enable_flat) != '0));
endmodule

// File: tb/bus_err_collector_bench.sv
module bus_err_collector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] err_lines = '0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic          irq;

    int checks = 0, errors = 0;
    logic [31:0] rv;

    bus_err_collector #(.NUM_LINES(NL), .AUX_CFG(3'd5), .REV_MAJOR(4'd2), .REV_MINOR(4'd7))
    u_bus_err_collector (
        .clk(clk), .rst_n(rst_n), .err_lines(err_lines), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk); err_lines[n] = 1'b1;
        @(negedge clk); err_lines[n] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rdata", rsp_rdata, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        rd(10'h100, rv); chk("R1 ctrl", rv, 32'h0);
        for (int b = 0; b < 2; b++) begin
            rd(10'(4*b), rv);        chk("R1 enable", rv, 32'h0);
            rd(10'(10'h040 + 4*b), rv); chk("R1 status", rv, 32'h0);
        end
        // R2 edge lost while capture is off
        pulse(3);
        rd(10'h040, rv); chk("R2 disabled edge", rv, 32'h0);
        // R8 control readback
        wr(10'h100, 32'hFFFF_FFFF);
        rd(10'h100, rv); chk("R8 ctrl", rv, 32'h1);
        // R2/R4 sweep every line ID
        for (int n = 0; n < NL; n++) begin
            pulse(n);
            rd(10'(10'h040 + 4*(n/32)), rv); chk("R2 sweep set", rv, 32'h1 << (n%32));
            chk("R6 no irq without enable", {31'd0, irq}, 32'h0);
            wr(10'(10'h080 + 4*(n/32)), 32'h1 << (n%32));
            rd(10'(10'h040 + 4*(n/32)), rv); chk("R4 sweep cleared", rv, 32'h0);
        end
        // R3 sticky, R4 zero bits no effect, clear reads zero
        pulse(1); pulse(9);
        repeat (3) @(negedge clk);
        rd(10'h040, rv); chk("R3 sticky", rv, 32'h202);
        wr(10'h080, 32'h0000_0002);
        rd(10'h040, rv); chk("R4 partial clear", rv, 32'h200);
        rd(10'h080, rv); chk("R4 clear reads zero", rv, 32'h0);
        wr(10'h080, 32'hFFFF_FFFF);
        rd(10'h040, rv); chk("R4 clear all", rv, 32'h0);
        // R2 held line gives one event only
        @(negedge clk); err_lines[4] = 1'b1;
        wr(10'h080, 32'h10);
        repeat (3) @(negedge clk);
        rd(10'h040, rv); chk("R2 held no re-event", rv, 32'h0);
        @(negedge clk); err_lines[4] = 1'b0;
        // R5 event and clear in the same cycle
        wr(10'h080, 32'hFFFF_FFFF);
        @(negedge clk);
        err_lines[7] = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h080; req_wdata = 32'h80;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; err_lines[7] = 1'b0;
        rd(10'h040, rv); chk("R5 event wins", rv, 32'h80);
        wr(10'h080, 32'h80);
        // R6 enable and irq level
        wr(10'h000, 32'h20);
        rd(10'h000, rv); chk("R6 enable readback", rv, 32'h20);
        pulse(6);
        chk("R6 irq off for disabled bit", {31'd0, irq}, 32'h0);
        pulse(5);
        chk("R6 irq on", {31'd0, irq}, 32'h1);
        wr(10'h080, 32'h20);
        chk("R6 irq drops", {31'd0, irq}, 32'h0);
        wr(10'h080, 32'h40);
        wr(10'h004, 32'hFFFF_FFFF);
        pulse(38);
        chk("R6 irq bank1", {31'd0, irq}, 32'h1);
        wr(10'h084, 32'hFFFF_FFFF);
        // R7 unimplemented IDs and banks
        rd(10'h004, rv); chk("R7 enable bank1 mask", rv, 32'h0000_00FF);
        wr(10'h008, 32'hFFFF_FFFF);
        rd(10'h008, rv); chk("R7 absent bank enable", rv, 32'h0);
        rd(10'h048, rv); chk("R7 absent bank status", rv, 32'h0);
        // R9 discovery registers and ignored writes
        rd(10'h3F0, rv); chk("R9 cfg", rv, 32'h0005_0028);
        rd(10'h3F4, rv); chk("R9 ver", rv, 32'h0000_0027);
        wr(10'h3F0, 32'h0); wr(10'h3F4, 32'h0); wr(10'h040, 32'hFFFF_FFFF);
        rd(10'h3F0, rv); chk("R9 cfg write ignored", rv, 32'h0005_0028);
        rd(10'h3F4, rv); chk("R9 ver write ignored", rv, 32'h0000_0027);
        rd(10'h040, rv); chk("R9 status write ignored", rv, 32'h0);
        // R10 unmapped address and hold
        rd(10'h3F0, rv);
        rd(10'h200, rv); chk("R10 unmapped", rv, 32'h0);
        rd(10'h3F4, rv);
        repeat (4) @(negedge clk);
        chk("R10 rdata holds", rsp_rdata, 32'h0000_0027);
        // R2 capture off again loses edge
        wr(10'h100, 32'h0);
        pulse(2);
        rd(10'h040, rv); chk("R2 capture off", rv, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule